// File: doc/BRIEF.md
# SMBus Block-Transfer Master

This block is a register-driven SMBus/I2C master. Software fills in a target address, a command byte, a length code and, for writes, a data buffer of sixteen halfwords. It then sets a single launch bit. The controller runs the whole transaction on its own, with no software help between bytes. It drives the open-drain clock and data lines, and it reports the outcome through a completion flag, an acknowledge-error flag and an optional interrupt.

A write transaction sends a start condition, the address with the write bit, the command byte, N data bytes and a stop condition. A read transaction sends the address and command in the same way, then a repeated start and the address with the read bit. It then receives N bytes, acknowledging each one except the last, and ends with a stop. In the buffer, each halfword holds two bus bytes. The earlier byte goes in the upper half. A soft-reset bit abandons any transaction, releases both lines and holds the busy flag for a short, fixed recovery time.

The register port is indexed by halfword. Index 0 is control, 1 is target, 2 is mode and 3 is command. When the top index bit is set, the low bits select a buffer word.

Top module: `smb_master`

## Requirements
- R1: After reset, the control register reads 0, irq_o is 0, and scl_o and sda_o are both 1 (released).
- R2: A write transaction puts on the bus: start, target[7:1] with R/W=0, the command byte (command register bits [7:0]), N data bytes, then stop. Buffer byte k is bits [15:8] of word k/2 when k is even, and bits [7:0] when k is odd.
- R3: Mode bits [1:0] select N: 00 gives 1 byte, 01 gives 8, 10 gives 16 and 11 gives 32.
- R4: Target bit 0 = 1 selects a read. After the command byte the block issues a repeated start and target[7:1] with R/W=1, then receives N bytes into the buffer in the R2 byte order. It acknowledges every byte except the last, which gets a NACK, and then sends a stop.
- R5: A NACK on the address, command or any written data byte ends the transaction with a stop. It also sets control bit 3 (ack error) and control bit 1 (done). Data bytes already acknowledged have been delivered.
- R6: Control bit 1 is set when a transaction ends and is cleared by writing 1 to it. irq_o is high exactly while bit 1 and control bit 6 (interrupt enable) are both 1.
- R7: Control bit 2 (busy) reads 1 from launch until the stop completes. Writing control bit 0 while busy is 1 starts no new transaction.
- R8: Writing control bit 4 aborts any transaction and releases both lines on the next cycle. It clears bits 1 and 3, and keeps bit 2 high for RST_CYC cycles. The aborted transaction never sets bit 1.
- R9: Mode bit 7 = 1 selects fast timing, with an SCL high time of 2*Q_FAST clocks. Mode bit 7 = 0 gives 2*Q_STD clocks. Start and stop setup and hold times are each one quarter period.
- R10: SDA changes while SCL stays high only as part of a start or stop condition.
- R11: While busy is 0, both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_idx_i | input | 5 | Halfword register index |
| reg_wdata_i | input | 16 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Completion interrupt |
| scl_i | input | 1 | Sensed clock line |
| scl_o | output | 1 | Clock drive, 0 pulls low, 1 releases |
| sda_i | input | 1 | Sensed data line |
| sda_o | output | 1 | Data drive, 0 pulls low, 1 releases |

## Verification
The bench builds the block with Q_STD=4, Q_FAST=2 and RST_CYC=8. With these values a bit takes only 8 or 16 clocks, so full 32-byte reads and writes in both timing modes fit in a short run. The quarter-period values also stay distinct enough that measuring the SCL high time shows which mode is active. The short reset window lets the bench watch busy fall after an abort that interrupts a long block write.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [1:0] {BC_START, BC_STOP, BC_WBIT, BC_RBIT} bit_cmd_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_START, SQ_ADDR_W, SQ_CMD, SQ_RSTART, SQ_ADDR_R, SQ_WR, SQ_RD, SQ_STOP
  } seq_st_e;

  localparam int unsigned CB_GO   = 0;
  localparam int unsigned CB_DONE = 1;
  localparam int unsigned CB_BUSY = 2;
  localparam int unsigned CB_NAK  = 3;
  localparam int unsigned CB_SRST = 4;
  localparam int unsigned CB_IEN  = 6;

  function automatic logic [5:0] len_of(logic [1:0] code);
    case (code)
      2'b00:   len_of = 6'd1;
      2'b01:   len_of = 6'd8;
      2'b10:   len_of = 6'd16;
      default: len_of = 6'd32;
    endcase
  endfunction

  // {scl, sda} for each quarter phase of a bit-level command
  function automatic logic [1:0] bit_drive(bit_cmd_e c, logic [1:0] ph, logic b);
    case (c)
      BC_START: case (ph)
        2'd0: bit_drive = 2'b01;
        2'd1: bit_drive = 2'b11;
        2'd2: bit_drive = 2'b10;
        default: bit_drive = 2'b00;
      endcase
      BC_STOP: case (ph)
        2'd0: bit_drive = 2'b00;
        2'd1: bit_drive = 2'b10;
        default: bit_drive = 2'b11;
      endcase
      BC_WBIT: bit_drive = {(ph == 2'd1 || ph == 2'd2), b};
      default: bit_drive = {(ph == 2'd1 || ph == 2'd2), 1'b1};
    endcase
  endfunction
endpackage

// File: rtl/smb_bit_eng.sv
module smb_bit_eng
  import smb_pkg::*;
#(
  parameter int unsigned Q_STD  = 125,
  parameter int unsigned Q_FAST = 32
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     abort_i,
  input  logic     fast_i,
  input  logic     cmd_valid_i,
  input  bit_cmd_e cmd_i,
  input  logic     bit_i,
  output logic     done_o,
  output logic     bit_o,
  output logic     cond_o,
  input  logic     scl_i,
  input  logic     sda_i,
  output logic     scl_o,
  output logic     sda_o
);
  localparam int unsigned QMAX = (Q_STD > Q_FAST) ? Q_STD : Q_FAST;
  localparam int unsigned CW   = $clog2(QMAX + 1);

  logic          act_q, bit_q, scl_q, sda_q, done_q, rbit_q;
  bit_cmd_e      cmd_q;
  logic [1:0]    ph_q;
  logic [CW-1:0] cnt_q, qlim;
  logic          stall;

  assign qlim  = fast_i ? CW'(Q_FAST) : CW'(Q_STD);
  assign stall = (ph_q == 2'd1) && !scl_i;  // wait for a stretched clock

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; bit_q <= 1'b1; cmd_q <= BC_STOP; ph_q <= '0; cnt_q <= '0;
      scl_q <= 1'b1; sda_q <= 1'b1; done_q <= 1'b0; rbit_q <= 1'b1;
    end else if (abort_i) begin
      act_q <= 1'b0; scl_q <= 1'b1; sda_q <= 1'b1; done_q <= 1'b0; ph_q <= '0; cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (cmd_valid_i) begin
          act_q <= 1'b1; cmd_q <= cmd_i; bit_q <= bit_i; ph_q <= '0; cnt_q <= '0;
          {scl_q, sda_q} <= bit_drive(cmd_i, 2'd0, bit_i);
        end
      end else if (!stall) begin
        if (cnt_q == qlim - 1'b1) begin
          cnt_q <= '0;
          if (ph_q == 2'd3) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            ph_q <= ph_q + 1'b1;
            {scl_q, sda_q} <= bit_drive(cmd_q, ph_q + 1'b1, bit_q);
            if (ph_q == 2'd1) rbit_q <= sda_i;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign bit_o  = rbit_q;
  assign scl_o  = scl_q;
  assign sda_o  = sda_q;
  assign cond_o = act_q && (cmd_q == BC_START || cmd_q == BC_STOP);
endmodule

// File: rtl/smb_seq.sv
module smb_seq
  import smb_pkg::*;
#(
  parameter int unsigned BI = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          abort_i,
  input  logic          go_i,
  input  logic [7:0]    tgt_i,
  input  logic [7:0]    cmd_i,
  input  logic [1:0]    len_code_i,
  input  logic [7:0]    tx_byte_i,
  output logic [BI-1:0] byte_idx_o,
  output logic          rx_we_o,
  output logic [7:0]    rx_byte_o,
  output logic          eng_valid_o,
  output bit_cmd_e      eng_cmd_o,
  output logic          eng_bit_o,
  input  logic          eng_done_i,
  input  logic          eng_bit_i,
  output logic          busy_o,
  output logic          fin_o,
  output logic          nak_o
);
  seq_st_e       st_q;
  logic          pend_q, nak_q, fin_q, rx_we_q;
  logic [3:0]    bit_idx_q;
  logic [BI-1:0] idx_q;
  logic [7:0]    sh_q, rx_byte_q, tx_cur;
  logic          is_rx, last;

  assign is_rx = (st_q == SQ_RD);
  assign last  = ({1'b0, idx_q} == BI'(len_of(len_code_i) - 6'd1));

  always_comb begin
    case (st_q)
      SQ_ADDR_W: tx_cur = {tgt_i[7:1], 1'b0};
      SQ_ADDR_R: tx_cur = {tgt_i[7:1], 1'b1};
      SQ_CMD:    tx_cur = cmd_i;
      default:   tx_cur = tx_byte_i;
    endcase
    eng_bit_o = 1'b1;
    if (st_q == SQ_START || st_q == SQ_RSTART) eng_cmd_o = BC_START;
    else if (st_q == SQ_STOP)                  eng_cmd_o = BC_STOP;
    else if (bit_idx_q != 4'd8) begin
      eng_cmd_o = is_rx ? BC_RBIT : BC_WBIT;
      eng_bit_o = tx_cur[3'd7 - bit_idx_q[2:0]];
    end else begin
      eng_cmd_o = is_rx ? BC_WBIT : BC_RBIT;
      eng_bit_o = last;  // NACK only the final received byte
    end
  end

  assign eng_valid_o = !pend_q && (st_q != SQ_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SQ_IDLE; pend_q <= 1'b0; nak_q <= 1'b0; fin_q <= 1'b0; rx_we_q <= 1'b0;
      bit_idx_q <= '0; idx_q <= '0; sh_q <= '0; rx_byte_q <= '0;
    end else if (abort_i) begin
      st_q <= SQ_IDLE; pend_q <= 1'b0; fin_q <= 1'b0; rx_we_q <= 1'b0; nak_q <= 1'b0;
    end else begin
      fin_q   <= 1'b0;
      rx_we_q <= 1'b0;
      if (st_q == SQ_IDLE) begin
        if (go_i) begin
          st_q <= SQ_START; idx_q <= '0; bit_idx_q <= '0; nak_q <= 1'b0;
        end
      end else if (eng_valid_o) begin
        pend_q <= 1'b1;
      end else if (eng_done_i) begin
        pend_q <= 1'b0;
        case (st_q)
          SQ_START:  st_q <= SQ_ADDR_W;
          SQ_RSTART: st_q <= SQ_ADDR_R;
          SQ_STOP: begin
            st_q  <= SQ_IDLE;
            fin_q <= 1'b1;
          end
          default: begin
            if (bit_idx_q != 4'd8) begin
              bit_idx_q <= bit_idx_q + 1'b1;
              if (is_rx) sh_q <= {sh_q[6:0], eng_bit_i};
              if (is_rx && bit_idx_q == 4'd7) begin
                rx_we_q   <= 1'b1;
                rx_byte_q <= {sh_q[6:0], eng_bit_i};
              end
            end else begin
              bit_idx_q <= '0;
              if (!is_rx && eng_bit_i) begin
                nak_q <= 1'b1;
                st_q  <= SQ_STOP;
              end else begin
                case (st_q)
                  SQ_ADDR_W: st_q <= SQ_CMD;
                  SQ_CMD:    st_q <= tgt_i[0] ? SQ_RSTART : SQ_WR;
                  SQ_ADDR_R: st_q <= SQ_RD;
                  default: begin
                    if (last) st_q <= SQ_STOP;
                    else      idx_q <= idx_q + 1'b1;
                  end
                endcase
              end
            end
          end
        endcase
      end
    end
  end

  assign byte_idx_o = idx_q;
  assign rx_we_o    = rx_we_q;
  assign rx_byte_o  = rx_byte_q;
  assign busy_o     = (st_q != SQ_IDLE);
  assign fin_o      = fin_q;
  assign nak_o      = nak_q;
endmodule

// File: rtl/smb_regs.sv
module smb_regs
  import smb_pkg::*;
#(
  parameter int unsigned WORDS   = 16,
  parameter int unsigned RST_CYC = 16,
  localparam int unsigned WI     = $clog2(WORDS),
  localparam int unsigned BI     = WI + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [WI:0]   idx_i,
  input  logic [15:0]   wdata_i,
  input  logic          we_i,
  output logic [15:0]   rdata_o,
  input  logic          seq_busy_i,
  input  logic          fin_i,
  input  logic          nak_i,
  input  logic          rx_we_i,
  input  logic [BI-1:0] byte_idx_i,
  input  logic [7:0]    rx_byte_i,
  output logic [7:0]    tx_byte_o,
  output logic          go_o,
  output logic          srst_o,
  output logic          busy_o,
  output logic [7:0]    tgt_o,
  output logic [7:0]    cmd_o,
  output logic [1:0]    len_o,
  output logic          fast_o,
  output logic          irq_o
);
  localparam int unsigned RW = $clog2(RST_CYC + 1);

  logic          done_q, nak_q, ien_q, fast_q;
  logic [7:0]    tgt_q, cmd_q;
  logic [1:0]    len_q;
  logic [RW-1:0] rcnt_q;
  logic [15:0]   buf_q [WORDS];
  logic          ctrl_we, is_buf;

  assign is_buf  = idx_i[WI];
  assign ctrl_we = we_i && !is_buf && (idx_i[WI-1:0] == '0);
  assign busy_o  = seq_busy_i || (rcnt_q != '0);
  assign srst_o  = ctrl_we && wdata_i[CB_SRST];
  assign go_o    = ctrl_we && wdata_i[CB_GO] && !wdata_i[CB_SRST] && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0; nak_q <= 1'b0; ien_q <= 1'b0; fast_q <= 1'b0;
      tgt_q <= '0; cmd_q <= '0; len_q <= '0; rcnt_q <= '0;
    end else begin
      if (rcnt_q != '0) rcnt_q <= rcnt_q - 1'b1;
      if (ctrl_we) begin
        ien_q <= wdata_i[CB_IEN];
        if (wdata_i[CB_DONE]) done_q <= 1'b0;
      end
      if (we_i && !is_buf) begin
        case (idx_i[WI-1:0])
          WI'(1): tgt_q <= wdata_i[7:0];
          WI'(2): begin len_q <= wdata_i[1:0]; fast_q <= wdata_i[7]; end
          WI'(3): cmd_q <= wdata_i[7:0];
          default: ;
        endcase
      end
      if (go_o) nak_q <= 1'b0;
      if (fin_i) begin
        done_q <= 1'b1;
        nak_q  <= nak_i;
      end
      if (srst_o) begin
        done_q <= 1'b0;
        nak_q  <= 1'b0;
        rcnt_q <= RW'(RST_CYC);
      end
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) buf_q[w] <= '0;
      else if (rx_we_i && byte_idx_i[BI-1:1] == WI'(w)) begin
        if (byte_idx_i[0]) buf_q[w][7:0]  <= rx_byte_i;
        else               buf_q[w][15:8] <= rx_byte_i;
      end else if (we_i && is_buf && idx_i[WI-1:0] == WI'(w)) buf_q[w] <= wdata_i;
    end
  end

  assign tx_byte_o = byte_idx_i[0] ? buf_q[byte_idx_i[BI-1:1]][7:0]
                                   : buf_q[byte_idx_i[BI-1:1]][15:8];

  always_comb begin
    rdata_o = '0;
    if (is_buf) rdata_o = buf_q[idx_i[WI-1:0]];
    else begin
      case (idx_i[WI-1:0])
        WI'(0): begin
          rdata_o[CB_DONE] = done_q;
          rdata_o[CB_BUSY] = busy_o;
          rdata_o[CB_NAK]  = nak_q;
          rdata_o[CB_IEN]  = ien_q;
        end
        WI'(1): rdata_o[7:0] = tgt_q;
        WI'(2): rdata_o[7:0] = {fast_q, 5'b0, len_q};
        WI'(3): rdata_o[7:0] = cmd_q;
        default: ;
      endcase
    end
  end

  assign tgt_o  = tgt_q;
  assign cmd_o  = cmd_q;
  assign len_o  = len_q;
  assign fast_o = fast_q;
  assign irq_o  = done_q && ien_q;
endmodule

// File: rtl/smb_master.sv
module smb_master
  import smb_pkg::*;
#(
  parameter int unsigned Q_STD   = 125,
  parameter int unsigned Q_FAST  = 32,
  parameter int unsigned RST_CYC = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [4:0]  reg_idx_i,
  input  logic [15:0] reg_wdata_i,
  input  logic        reg_we_i,
  output logic [15:0] reg_rdata_o,
  output logic        irq_o,
  input  logic        scl_i,
  output logic        scl_o,
  input  logic        sda_i,
  output logic        sda_o
);
  localparam int unsigned WORDS = 16;
  localparam int unsigned BI    = $clog2(WORDS) + 1;

  logic          go_w, srst_w, busy_w, seq_busy_w, fin_w, nak_w, rx_we_w, fast_w, cond_w;
  logic          eng_valid_w, eng_bit_w, eng_done_w, eng_rbit_w;
  bit_cmd_e      eng_cmd_w;
  logic [7:0]    tgt_w, cmd_w, tx_byte_w, rx_byte_w;
  logic [1:0]    len_w;
  logic [BI-1:0] byte_idx_w;

  smb_regs #(.WORDS(WORDS), .RST_CYC(RST_CYC)) u_regs (
    .clk_i, .rst_ni, .idx_i(reg_idx_i), .wdata_i(reg_wdata_i), .we_i(reg_we_i),
    .rdata_o(reg_rdata_o), .seq_busy_i(seq_busy_w), .fin_i(fin_w), .nak_i(nak_w),
    .rx_we_i(rx_we_w), .byte_idx_i(byte_idx_w), .rx_byte_i(rx_byte_w),
    .tx_byte_o(tx_byte_w), .go_o(go_w), .srst_o(srst_w), .busy_o(busy_w),
    .tgt_o(tgt_w), .cmd_o(cmd_w), .len_o(len_w), .fast_o(fast_w), .irq_o(irq_o)
  );

  smb_seq #(.BI(BI)) u_seq (
    .clk_i, .rst_ni, .abort_i(srst_w), .go_i(go_w), .tgt_i(tgt_w), .cmd_i(cmd_w),
    .len_code_i(len_w), .tx_byte_i(tx_byte_w), .byte_idx_o(byte_idx_w),
    .rx_we_o(rx_we_w), .rx_byte_o(rx_byte_w), .eng_valid_o(eng_valid_w),
    .eng_cmd_o(eng_cmd_w), .eng_bit_o(eng_bit_w), .eng_done_i(eng_done_w),
    .eng_bit_i(eng_rbit_w), .busy_o(seq_busy_w), .fin_o(fin_w), .nak_o(nak_w)
  );

  smb_bit_eng #(.Q_STD(Q_STD), .Q_FAST(Q_FAST)) u_eng (
    .clk_i, .rst_ni, .abort_i(srst_w), .fast_i(fast_w), .cmd_valid_i(eng_valid_w),
    .cmd_i(eng_cmd_w), .bit_i(eng_bit_w), .done_o(eng_done_w), .bit_o(eng_rbit_w),
    .cond_o(cond_w), .scl_i, .sda_i, .scl_o, .sda_o
  );
endmodule

// File: rtl/smb_master_chk.sv
module smb_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_o,
  input logic sda_o,
  input logic busy,
  input logic go,
  input logic srst,
  input logic fin,
  input logic cond
);
  p_idle_released_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (scl_o && sda_o));

  p_launch_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> busy);

  p_srst_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (busy && scl_o && sda_o));

  p_fin_after_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |-> (scl_o && sda_o));

  p_sda_only_cond_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && $past(scl_o) && !$stable(sda_o) && !$past(srst)) |-> $past(cond));
endmodule

bind smb_master smb_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_o(scl_o), .sda_o(sda_o), .busy(busy_w),
  .go(go_w), .srst(srst_w), .fin(fin_w), .cond(cond_w)
);

// File: tb/smb_master_tb_top.sv
module smb_master_tb_top;
  localparam int QS = 4, QF = 2, RC = 8;
  localparam logic [6:0] SLV = 7'h3A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] idx = '0;
  logic [15:0] wdata = '0, rdata;
  logic we = 1'b0, irq, scl_o_w, sda_o_w;
  logic slv_sda = 1'b1;
  wire sda_bus = sda_o_w & slv_sda;
  wire scl_bus = scl_o_w;

  always #2 clk = ~clk;

  smb_master #(.Q_STD(QS), .Q_FAST(QF), .RST_CYC(RC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_idx_i(idx), .reg_wdata_i(wdata), .reg_we_i(we),
    .reg_rdata_o(rdata), .irq_o(irq), .scl_i(scl_bus), .scl_o(scl_o_w),
    .sda_i(sda_bus), .sda_o(sda_o_w)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- bus target model ----------------
  logic [7:0] mem [64];
  logic [7:0] s_sh = '0;
  bit s_act = 0, s_rd = 0, s_rdnext = 0, s_lastnak = 0, s_mnak = 0;
  int s_bitc = 0, s_byte = 0, s_ptr = 0;
  int starts = 0, wr_cnt = 0, m_ack = 0, m_nak = 0, nak_at = 0;

  always @(negedge sda_bus) if (scl_bus === 1'b1) begin
    starts++; s_act = 1; s_bitc = 0; s_byte = 0; s_rd = 0; s_rdnext = 0;
    s_lastnak = 0; s_mnak = 0; slv_sda = 1'b1;
  end
  always @(posedge sda_bus) if (scl_bus === 1'b1) begin
    s_act = 0; slv_sda = 1'b1;
  end
  always @(posedge scl_bus) if (s_act) begin
    if (s_bitc < 8) begin
      if (!s_rd) s_sh = {s_sh[6:0], sda_bus};
      s_bitc++;
    end else begin
      if (s_rd) begin
        if (sda_bus) begin m_nak++; s_mnak = 1; end
        else m_ack++;
      end
      s_bitc = 0; s_byte++;
    end
  end
  always @(negedge scl_bus) if (s_act) begin
    if (s_bitc == 8) begin
      if (s_rd) slv_sda = 1'b1;
      else begin
        bit ack;
        ack = 1;
        if (s_byte == 0) begin
          ack = (s_sh[7:1] == SLV);
          s_rdnext = ack && s_sh[0];
        end else if (s_byte == 1) s_ptr = int'(s_sh);
        else begin
          mem[s_ptr % 64] = s_sh; s_ptr++; wr_cnt++;
          if (wr_cnt == nak_at) ack = 0;
        end
        slv_sda = !ack; s_lastnak = !ack;
      end
    end else if (s_bitc == 0) begin
      if (s_lastnak || s_mnak) begin s_act = 0; slv_sda = 1'b1; end
      else begin
        if (s_rdnext) begin s_rd = 1; s_rdnext = 0; end
        if (s_rd) begin s_sh = mem[s_ptr % 64]; s_ptr++; slv_sda = s_sh[7]; end
        else slv_sda = 1'b1;
      end
    end else slv_sda = s_rd ? s_sh[7 - s_bitc] : 1'b1;
  end

  // ---------------- register access ----------------
  task automatic wr(input int i, input int d);
    @(negedge clk); idx = 5'(i); wdata = 16'(d); we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask
  task automatic rd(input int i, output logic [15:0] d);
    @(negedge clk); idx = 5'(i); #1; d = rdata;
  endtask
  task automatic wait_done(input string req);
    logic [15:0] c;
    for (int n = 0; n < 20000; n++) begin
      rd(0, c);
      if (c[1]) return;
    end
    chk(0, req, 0, 1);
  endtask

  function automatic int nbytes(input int code);
    return (code == 0) ? 1 : (code == 1) ? 8 : (code == 2) ? 16 : 32;
  endfunction

  logic [7:0] eb [32];

  task automatic do_xfer(input int code, input bit rdir, input bit fast, input int cmd);
    logic [15:0] d;
    bit ok;
    int n;
    n = nbytes(code);
    for (int k = 0; k < 32; k++) eb[k] = 8'($urandom);
    if (rdir) for (int k = 0; k < n; k++) mem[(cmd + k) % 64] = eb[k];
    else for (int w = 0; w < 16; w++) wr(16 + w, {eb[2*w], eb[2*w+1]});
    wr(0, 16'h0002);
    wr(1, {SLV, rdir});
    wr(2, {fast, 5'b0, 2'(code)});
    wr(3, cmd);
    wr_cnt = 0; m_ack = 0; m_nak = 0; nak_at = 0;
    wr(0, 16'h0001);
    wait_done(rdir ? "R4" : "R2");
    rd(0, d);
    chk(d[3] == 1'b0, "R5 no ack error on good transfer", int'(d[3]), 0);
    ok = 1;
    if (rdir) begin
      for (int k = 0; k < n; k++) begin
        rd(16 + k / 2, d);
        if ((k % 2 == 0 ? d[15:8] : d[7:0]) != eb[k]) ok = 0;
      end
      chk(ok, $sformatf("R4 R3 read data code %0d", code), int'(d), int'(eb[n-1]));
      chk(m_ack == n - 1 && m_nak == 1, "R4 ack pattern", m_ack, n - 1);
    end else begin
      for (int k = 0; k < n; k++) if (mem[(cmd + k) % 64] != eb[k]) ok = 0;
      chk(ok && wr_cnt == n, $sformatf("R2 R3 write data code %0d", code), wr_cnt, n);
    end
  endtask

  task automatic meas_high(output int h);
    @(posedge scl_o_w);
    h = 0;
    while (scl_o_w) begin
      @(negedge clk);
      if (scl_o_w) h++;
    end
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int h, st0;
    void'($urandom(32'd4242));
    for (int k = 0; k < 64; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    chk(scl_o_w && sda_o_w && !irq, "R1 lines and irq at reset", {scl_o_w, sda_o_w, irq}, 3'b110);
    rst_n = 1'b1;
    rd(0, d);
    chk(d == 16'h0, "R1 control at reset", d, 0);

    // random mix across all length codes, both directions and rates
    for (int t = 0; t < 8; t++)
      do_xfer(t % 4, t[2], t[0], int'($urandom % 32));
    do_xfer(3, 1, 1, 5);
    do_xfer(3, 0, 0, 40);

    // R9 rate measurement
    wr(1, {SLV, 1'b0}); wr(2, 16'h0003); wr(3, 0); wr(0, 16'h0001);
    repeat (80) @(negedge clk);
    meas_high(h);
    chk(h == 2 * QS, "R9 standard SCL high", h, 2 * QS);
    wait_done("R9");
    wr(2, 16'h0083); wr(0, 16'h0003);
    repeat (80) @(negedge clk);
    meas_high(h);
    chk(h == 2 * QF, "R9 fast SCL high", h, 2 * QF);
    wait_done("R9");

    // R5 address NAK
    wr(0, 16'h0002);
    wr(1, {7'h11, 1'b0}); wr(2, 16'h0001);
    wr_cnt = 0; wr(0, 16'h0001);
    wait_done("R5");
    rd(0, d);
    chk(d[3] && d[1] && !d[2], "R5 address NAK flags", d, 16'h000a);
    chk(wr_cnt == 0 && scl_o_w && sda_o_w, "R5 nothing written, bus released", wr_cnt, 0);

    // R5 data NAK on third data byte
    wr(0, 16'h0002);
    wr(1, {SLV, 1'b0}); wr(2, 16'h0001); wr(3, 8);
    wr_cnt = 0; nak_at = 3; wr(0, 16'h0001);
    wait_done("R5");
    rd(0, d);
    chk(d[3] && d[1], "R5 data NAK flags", d, 16'h000a);
    chk(wr_cnt == 3, "R5 bytes delivered before NAK", wr_cnt, 3);
    nak_at = 0;

    // R6 interrupt and write-one-to-clear
    wr(0, 16'h0042);
    wr(2, 16'h0000); wr(0, 16'h0041);
    wait_done("R6");
    @(negedge clk);
    chk(irq == 1'b1, "R6 irq with enable", irq, 1);
    wr(0, 16'h0040);
    rd(0, d);
    chk(irq && d[1], "R6 writing 0 keeps done", d, 16'h0042);
    wr(0, 16'h0042);
    rd(0, d);
    chk(!irq && !d[1], "R6 W1C clears done and irq", d, 16'h0040);
    wr(0, 16'h0001);
    wait_done("R6");
    wr(0, 16'h0000);
    @(negedge clk);
    chk(!irq, "R6 irq masked when disabled", irq, 0);

    // R7 launch while busy is ignored
    wr(0, 16'h0002);
    wr(2, 16'h0001);
    st0 = starts;
    wr(0, 16'h0001);
    repeat (60) @(negedge clk);
    rd(0, d);
    chk(d[2] == 1'b1, "R7 busy during transfer", d, 16'h0004);
    wr(0, 16'h0001);
    wait_done("R7");
    repeat (200) @(negedge clk);
    rd(0, d);
    chk(starts - st0 == 1 && !d[2], "R7 second launch ignored", starts - st0, 1);

    // R8 soft reset mid-transfer
    wr(0, 16'h0002);
    wr(2, 16'h0003);
    wr(0, 16'h0001);
    repeat (300) @(negedge clk);
    wr(0, 16'h0010);
    s_act = 0; slv_sda = 1'b1;
    chk(scl_o_w && sda_o_w, "R8 lines released after abort", {scl_o_w, sda_o_w}, 2'b11);
    rd(0, d);
    chk(d[2] && !d[1] && !d[3], "R8 busy during recovery", d, 16'h0004);
    repeat (RC + 2) @(negedge clk);
    rd(0, d);
    chk(d == 16'h0, "R8 idle after recovery, no done", d, 0);
    repeat (400) @(negedge clk);
    rd(0, d);
    chk(!d[1] && scl_o_w && sda_o_w, "R8 R11 aborted transfer stays silent", d, 0);

    // recovery: a fresh transfer works
    do_xfer(1, 1, 0, 12);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule